// File: doc/BRIEF.md
# DMA Channel Register Front End

This block is the processor-facing register set of a four-channel DMA controller. Software writes a source address, a destination address, a transfer count and a control word for each channel through one write port. The block filters each write by channel: it trims addresses, rejects address ranges that a channel may not use, replaces a zero count with the channel's maximum, and masks control bits that the channel does not implement. The transfer engine, the arbiter and interrupt logic sit in neighbouring blocks and read the per-channel outputs.

When software sets the enable bit of a channel that is off, the block copies the stored addresses into working pointers. It also rewrites the source step mode for sources in the cartridge-ROM window, records a sticky flag if a working address is not aligned to the transfer unit, and sends the scheduler a one-cycle start request. Each channel runs a three-state machine. CH_IDLE (enable clear) moves to CH_START on a control write with enable set. CH_START (start request high) moves to CH_RUN, or back to CH_IDLE if that cycle brings a control write with enable clear. CH_RUN moves to CH_IDLE on a control write with enable clear. Any other control write leaves the state unchanged.

Write selector encoding: 0 source, 1 destination, 2 count, 3 control. Control word fields are: bits 6:5 destination step, bits 8:7 source step, bit 9 repeat, bit 10 unit width (0 for 2 bytes, 1 for 4 bytes), bit 11 external request (last channel only), bits 13:12 timing, bit 14 interrupt, bit 15 enable.

Top module: `dma_regfront`

## Requirements
- R1: A written address keeps bits 27:1 of the write data and stores bit 0 as zero (AND with 0x0FFFFFFE).
- R2: A source write is accepted if the trimmed address is at or above 0x02000000. On channel 0 a source in 0x08000000 to 0x0DFFFFFF is also rejected. A rejected source stores zero.
- R3: A destination write is always accepted on channel 3. On channels 0 to 2 it is accepted only below 0x08000000. A rejected destination keeps the previous value.
- R4: A count write uses data bits 15:0. A zero value stores 0x4000 on channels 0 to 2 and 0x10000 on channel 3. Reset loads these same values.
- R5: A control write is ANDed with 0xF7E0 on channels 0 to 2 and with 0xFFE0 on channel 3. `rd_ctl` returns the stored control word of the channel `rd_chan` selects. Reset clears all control words.
- R6: A control write that sets bit 15 while the channel is in CH_IDLE copies the stored source and destination into the working pointers. In the cycle after the write, `start_req` for that channel is high for exactly one cycle.
- R7: At that enable edge, if the stored source lies in 0x08000000 to 0x0DFFFFFF and the written source step (bits 8:7) is below 3, bits 8:7 are stored as 0.
- R8: At that enable edge, if source or destination is not a multiple of the unit (2 bytes, or 4 bytes when bit 10 is set), `misalign` for that channel is set. It stays set until reset.
- R9: A control write while the channel is already enabled gives no start request. A control write that clears bit 15 returns the channel to CH_IDLE. The working pointers hold their values until the next enable edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_chan | input | 2 | Channel addressed by the write |
| wr_sel | input | 2 | Register selector (0 src, 1 dst, 2 count, 3 control) |
| wr_data | input | 32 | Write data |
| rd_chan | input | 2 | Channel for control readback |
| rd_ctl | output | 16 | Control word of channel rd_chan |
| ctl_all | output | 64 | Control words, channel n at bits 16n+15:16n |
| cnt_all | output | 68 | Counts, channel n at bits 17n+16:17n |
| work_src_all | output | 112 | Working source pointers, 28 bits per channel |
| work_dst_all | output | 112 | Working destination pointers, 28 bits per channel |
| start_req | output | 4 | One-cycle start request per channel |
| misalign | output | 4 | Sticky misalignment flag per channel |

## Verification
The assertions assume that at most one register write arrives per cycle. This keeps start requests one-hot across channels. They also assume that a channel's source register is not written in the same cycle as its enable edge, so the working source equals the source stored before that edge. The directed tasks drive a single write per cycle through one write task, so both assumptions always hold. Each scenario begins from reset, so sticky flags from earlier scenarios do not mask later results.

// File: rtl/dma_regfront_pkg.sv
`timescale 1ns/1ps
package dma_regfront_pkg;
    typedef enum logic [1:0] {
        SEL_SRC = 2'd0,
        SEL_DST = 2'd1,
        SEL_CNT = 2'd2,
        SEL_CTL = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_START = 2'd1,
        CH_RUN   = 2'd2
    } ch_state_e;

    localparam int ENABLE_BIT = 15;
    localparam int UNIT_BIT   = 10;
    localparam int SSTEP_LO   = 7;
    localparam int SSTEP_HI   = 8;
endpackage

// File: rtl/dma_addr_check.sv
`timescale 1ns/1ps
module dma_addr_check #(
    parameter int          CH       = 0,
    parameter int          NCH      = 4,
    parameter int          AW       = 28,
    parameter logic [27:0] RAM_BASE = 28'h200_0000,
    parameter logic [27:0] ROM_BASE = 28'h800_0000,
    parameter logic [27:0] ROM_END  = 28'hE00_0000
) (
    input  logic [31:0]   raw,
    output logic [AW-1:0] addr,
    output logic          src_ok,
    output logic          dst_ok
);
    logic in_rom;

    always_comb begin
        addr   = {raw[AW-1:1], 1'b0};
        in_rom = (addr >= ROM_BASE) && (addr < ROM_END);
    end

    generate
        if (CH == 0) begin : g_first
            assign src_ok = (addr >= RAM_BASE) && !in_rom;
        end else begin : g_other
            assign src_ok = (addr >= RAM_BASE);
        end
        if (CH == NCH - 1) begin : g_last
            assign dst_ok = 1'b1;
        end else begin : g_lower
            assign dst_ok = (addr < ROM_BASE);
        end
    endgenerate
endmodule

// File: rtl/dma_chan_regs.sv
`timescale 1ns/1ps
module dma_chan_regs
    import dma_regfront_pkg::*;
#(
    parameter int          CH       = 0,
    parameter int          NCH      = 4,
    parameter int          AW       = 28,
    parameter int          CW       = 17,
    parameter logic [27:0] RAM_BASE = 28'h200_0000,
    parameter logic [27:0] ROM_BASE = 28'h800_0000,
    parameter logic [27:0] ROM_END  = 28'hE00_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  reg_sel_e      sel,
    input  logic [31:0]   data,
    output logic [AW-1:0] src_work,
    output logic [AW-1:0] dst_work,
    output logic [CW-1:0] cnt,
    output logic [15:0]   ctl,
    output logic          start_req,
    output logic          misal
);
    localparam bit          IS_LAST  = (CH == NCH - 1);
    localparam logic [15:0] CTL_MASK = IS_LAST ? 16'hFFE0 : 16'hF7E0;
    localparam logic [CW-1:0] CNT_DFLT = IS_LAST ? CW'(32'h1_0000) : CW'(32'h4000);

    ch_state_e     state_q, state_d;
    logic [AW-1:0] src_q, dst_q, addr_in;
    logic          src_ok, dst_ok;
    logic [15:0]   ctl_in, ctl_fixed;
    logic          ctl_we, rise, src_rom, mis_now;
    logic [AW-1:0] unit_mask;

    dma_addr_check #(
        .CH(CH), .NCH(NCH), .AW(AW),
        .RAM_BASE(RAM_BASE), .ROM_BASE(ROM_BASE), .ROM_END(ROM_END)
    ) u_chk (
        .raw(data), .addr(addr_in), .src_ok(src_ok), .dst_ok(dst_ok)
    );

    always_comb begin
        ctl_in    = data[15:0] & CTL_MASK;
        ctl_we    = we && (sel == SEL_CTL);
        rise      = ctl_we && ctl_in[ENABLE_BIT] && (state_q == CH_IDLE);
        src_rom   = (src_q >= ROM_BASE) && (src_q < ROM_END);
        ctl_fixed = ctl_in;
        if (rise && src_rom && (ctl_in[SSTEP_HI:SSTEP_LO] != 2'b11))
            ctl_fixed[SSTEP_HI:SSTEP_LO] = 2'b00;
        unit_mask = ctl_in[UNIT_BIT] ? AW'(3) : AW'(1);
        mis_now   = ((src_q | dst_q) & unit_mask) != '0;
    end

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE:  if (ctl_we && ctl_in[ENABLE_BIT]) state_d = CH_START;
            CH_START: state_d = (ctl_we && !ctl_in[ENABLE_BIT]) ? CH_IDLE : CH_RUN;
            CH_RUN:   if (ctl_we && !ctl_in[ENABLE_BIT]) state_d = CH_IDLE;
            default:  state_d = CH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // output process
    always_comb begin
        start_req = (state_q == CH_START);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q    <= '0;
            dst_q    <= '0;
            cnt      <= CNT_DFLT;
            ctl      <= '0;
            src_work <= '0;
            dst_work <= '0;
            misal    <= 1'b0;
        end else begin
            if (we && sel == SEL_SRC) src_q <= src_ok ? addr_in : '0;
            if (we && sel == SEL_DST && dst_ok) dst_q <= addr_in;
            if (we && sel == SEL_CNT)
                cnt <= (data[15:0] == 16'h0) ? CNT_DFLT : CW'(data[15:0]);
            if (ctl_we) ctl <= ctl_fixed;
            if (rise) begin
                src_work <= src_q;
                dst_work <= dst_q;
                if (mis_now) misal <= 1'b1;
            end
        end
    end

    // R6
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |=> !start_req);
    // R6
    latch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |-> (src_work == $past(src_q)));
    // R3
    dst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_DST && !dst_ok) |=> $stable(dst_q));
    // R4
    cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt != '0);
    // R8
    misal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misal |=> misal);
    // R5
    ctl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl[4:0] == 5'd0);
endmodule

// File: rtl/dma_regfront.sv
`timescale 1ns/1ps
module dma_regfront
    import dma_regfront_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 28,
    parameter int CW  = 17,
    localparam int CHW = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CHW-1:0]   wr_chan,
    input  logic [1:0]       wr_sel,
    input  logic [31:0]      wr_data,
    input  logic [CHW-1:0]   rd_chan,
    output logic [15:0]      rd_ctl,
    output logic [NCH*16-1:0] ctl_all,
    output logic [NCH*CW-1:0] cnt_all,
    output logic [NCH*AW-1:0] work_src_all,
    output logic [NCH*AW-1:0] work_dst_all,
    output logic [NCH-1:0]   start_req,
    output logic [NCH-1:0]   misalign
);
    logic [15:0] ctl_arr [NCH];
    reg_sel_e    sel;

    assign sel = reg_sel_e'(wr_sel);

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            logic [15:0] ctl_c;
            dma_chan_regs #(.CH(c), .NCH(NCH), .AW(AW), .CW(CW)) u_ch (
                .clk       (clk),
                .rst_n     (rst_n),
                .we        (wr_en && (wr_chan == CHW'(c))),
                .sel       (sel),
                .data      (wr_data),
                .src_work  (work_src_all[c*AW +: AW]),
                .dst_work  (work_dst_all[c*AW +: AW]),
                .cnt       (cnt_all[c*CW +: CW]),
                .ctl       (ctl_c),
                .start_req (start_req[c]),
                .misal     (misalign[c])
            );
            assign ctl_arr[c]          = ctl_c;
            assign ctl_all[c*16 +: 16] = ctl_c;
        end
    endgenerate

    assign rd_ctl = ctl_arr[rd_chan];

    // R6
    start_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start_req));
endmodule

// File: tb/dma_regfront_bench.sv
`timescale 1ns/1ps
module dma_regfront_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_chan = '0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_chan = '0;
    logic [15:0] rd_ctl;
    logic [63:0] ctl_all;
    logic [67:0] cnt_all;
    logic [111:0] work_src_all, work_dst_all;
    logic [3:0]  start_req, misalign;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dma_regfront u_dma_regfront (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_chan(rd_chan), .rd_ctl(rd_ctl),
        .ctl_all(ctl_all), .cnt_all(cnt_all), .work_src_all(work_src_all),
        .work_dst_all(work_dst_all), .start_req(start_req), .misalign(misalign)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic wr(input int ch, input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_chan = 2'(ch); wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] exp_src(input int ch, input logic [31:0] raw);
        logic [31:0] a = raw & 32'h0FFF_FFFE;
        if (a < 32'h0200_0000) return 0;
        if (ch == 0 && a >= 32'h0800_0000 && a < 32'h0E00_0000) return 0;
        return a;
    endfunction

    function automatic logic [31:0] wsrc(input int ch); return 32'(work_src_all[ch*28 +: 28]); endfunction
    function automatic logic [31:0] wdst(input int ch); return 32'(work_dst_all[ch*28 +: 28]); endfunction
    function automatic logic [31:0] ctlv(input int ch); return 32'(ctl_all[ch*16 +: 16]); endfunction
    function automatic logic [31:0] cntv(input int ch); return 32'(cnt_all[ch*17 +: 17]); endfunction

    task automatic t_reset_state();
        do_reset();
        for (int c = 0; c < 4; c++) begin
            chk("R5 reset ctl", ctlv(c), 0);
            chk("R4 reset count", cntv(c), (c == 3) ? 32'h10000 : 32'h4000);
            chk("R6 reset work src", wsrc(c), 0);
        end
        chk("R6 reset start", 32'(start_req), 0);
        chk("R8 reset misalign", 32'(misalign), 0);
    endtask

    task automatic t_enable_latch();
        do_reset();
        wr(1, 0, 32'hF300_0007);
        wr(1, 1, 32'h0600_1235);
        wr(1, 3, 32'h0000_881F);
        chk("R6 start pulse", 32'(start_req), 32'h2);
        chk("R1 work src trimmed", wsrc(1), exp_src(1, 32'hF300_0007));
        chk("R1 work dst trimmed", wdst(1), 32'h0600_1234);
        chk("R5 ch1 mask", ctlv(1), 32'h8000);
        @(negedge clk);
        chk("R6 pulse one cycle", 32'(start_req), 0);
        wr(1, 3, 32'h0000_8000);
        chk("R9 no pulse when enabled", 32'(start_req), 0);
        wr(1, 3, 32'h0000_0000);
        chk("R9 disable readback", ctlv(1), 0);
        wr(1, 0, 32'h0300_0000);
        chk("R9 work src holds", wsrc(1), 32'h0300_0006);
        wr(1, 3, 32'h0000_8000);
        chk("R9 re-enable pulse", 32'(start_req), 32'h2);
        chk("R9 re-enable latches", wsrc(1), 32'h0300_0000);
    endtask

    task automatic t_src_filter();
        do_reset();
        wr(0, 0, 32'h0800_0100);
        wr(0, 3, 32'h0000_8000);
        chk("R2 ch0 rom rejected", wsrc(0), exp_src(0, 32'h0800_0100));
        wr(0, 3, 0);
        wr(0, 0, 32'h0100_0000);
        wr(0, 3, 32'h0000_8000);
        chk("R2 below ram rejected", wsrc(0), 0);
        wr(2, 0, 32'h0800_0100);
        wr(2, 3, 32'h0000_8080);
        chk("R2 ch2 rom accepted", wsrc(2), exp_src(2, 32'h0800_0100));
        rd_chan = 2'd2; #1;
        chk("R7 step cleared", 32'(rd_ctl), 32'h8000);
        wr(3, 0, 32'h0800_0000);
        wr(3, 3, 32'h0000_8180);
        rd_chan = 2'd3; #1;
        chk("R7 step 3 kept", 32'(rd_ctl), 32'h8180);
        wr(3, 3, 0);
        wr(3, 0, 32'h0E00_0000);
        wr(3, 3, 32'h0000_8080);
        chk("R7 outside window kept", ctlv(3), 32'h8080);
    endtask

    task automatic t_dst_filter();
        do_reset();
        wr(0, 1, 32'h0300_0000);
        wr(0, 1, 32'h0800_0000);
        wr(0, 3, 32'h0000_8000);
        chk("R3 ch0 rejected keeps", wdst(0), 32'h0300_0000);
        wr(3, 1, 32'h0900_0000);
        wr(3, 3, 32'h0000_8000);
        chk("R3 ch3 any dst", wdst(3), 32'h0900_0000);
    endtask

    task automatic t_count_ctl();
        do_reset();
        wr(0, 2, 32'h0000_0005);
        chk("R4 count plain", cntv(0), 5);
        wr(0, 2, 32'h0001_0000);
        chk("R4 zero low half", cntv(0), 32'h4000);
        wr(3, 2, 0);
        chk("R4 ch3 zero", cntv(3), 32'h10000);
        wr(3, 3, 32'h0000_7FFF);
        rd_chan = 2'd3; #1;
        chk("R5 ch3 mask", 32'(rd_ctl), 32'h7FE0);
        wr(2, 3, 32'h0000_7FFF);
        rd_chan = 2'd2; #1;
        chk("R5 ch2 mask", 32'(rd_ctl), 32'h77E0);
    endtask

    task automatic t_misalign();
        do_reset();
        wr(0, 0, 32'h0200_0002);
        wr(0, 3, 32'h0000_8000);
        chk("R8 halfword aligned", 32'(misalign), 0);
        wr(1, 0, 32'h0200_0002);
        wr(1, 1, 32'h0200_0000);
        wr(1, 3, 32'h0000_8400);
        chk("R8 word misaligned", 32'(misalign), 32'h2);
        wr(1, 3, 0);
        wr(1, 0, 32'h0200_0004);
        wr(1, 3, 32'h0000_8400);
        chk("R8 sticky", 32'(misalign), 32'h2);
    endtask

    initial begin
        t_reset_state();
        t_enable_latch();
        t_src_filter();
        t_dst_filter();
        t_count_ctl();
        t_misalign();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule